// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits on the device side of a parallel flash-style bus and decides which bus write cycles form a valid protected command. Each write cycle arrives as an address, a data word and a one-clock write strobe that has already been synchronised to the system clock. The decoder keeps a small sequence state and accepts only fixed chains of address/data unlock cycles. A chain can end in a word program, a sector erase, a block erase or a whole-array erase. For each of these it raises a one-clock start pulse and presents the target address and data, taken from the write that completed the chain.

The same unlock prefix also switches the visible read mode between normal array reads, an identification mode and a query mode. In identification mode the decoder itself supplies the manufacturer and device codes. A write that does not fit the expected chain clears the sequence and puts the block back in array-read mode, so a single stray write is also the quick way out of the special modes. While the array controller reports an internal operation as busy, every write is dropped and leaves no trace, and the sequence state held before busy is kept.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After the writes AAh at 5555h, 55h at 2AAAh and A0h at 5555h, the next write at any address starts a word program. `start_prog` is high in the clock after that write's strobe, with `tgt_addr` and `tgt_data` equal to that write's full address and data.
- R2: After the five-write erase prefix AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, a sixth write of 30h at any address pulses `start_sect`. `tgt_addr` is then that address with bits 10..0 cleared, so the sector index is in bits 17..11.
- R3: After the erase prefix, a sixth write of 50h pulses `start_blk`. `tgt_addr` is then the address with bits 14..0 cleared, so the block index is in bits 17..15.
- R4: After the erase prefix, a sixth write of 10h at 5555h pulses `start_chip` with `tgt_addr` equal to zero. A write of 10h at any other address aborts as in R8.
- R5: The writes AAh@5555h, 55h@2AAAh followed by 90h@5555h set `mode` to 01 (identification). Followed by 98h@5555h instead, they set `mode` to 10 (query). `mode` 00 means array read.
- R6: `id_valid` is high only while `mode` is 01. In that mode, `rd_addr` 0 gives `id_data` = MFR_CODE, `rd_addr` 1 gives DEV_CODE, and any other address gives zero. Outside that mode `id_data` is zero.
- R7: A single write of F0h at any address returns `mode` to 00. The three-write chain ending in F0h at 5555h does the same.
- R8: A write that does not match the expected next cycle of a chain returns the sequence to idle and sets `mode` to 00, and no start pulse follows. This includes a write other than AAh@5555h when no chain is in progress.
- R9: A write whose strobe coincides with `busy` high is ignored. It gives no start pulse, `mode` does not change, and a partly entered chain carries on afterwards from where it was.
- R10: Command cycles compare only address bits 14..0 and data bits 7..0. Higher address bits and data bits 15..8 may hold any value.
- R11: A start pulse lasts exactly one clock, at most one start output is high at a time, and `mode` reads 00 while a start is shown.
- R12: Synchronous reset sets `mode` to 00, all start outputs low and `tgt_addr`/`tgt_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-clock pulse marking a bus write cycle |
| wr_addr | input | ADDR_W (18) | Address of the write cycle |
| wr_data | input | DATA_W (16) | Data of the write cycle |
| busy | input | 1 | Internal program/erase in progress |
| rd_addr | input | ADDR_W (18) | Read address, used for the identification codes |
| start_prog | output | 1 | One-clock word-program start |
| start_sect | output | 1 | One-clock sector-erase start |
| start_blk | output | 1 | One-clock block-erase start |
| start_chip | output | 1 | One-clock whole-array erase start |
| tgt_addr | output | ADDR_W (18) | Latched target address, aligned for erases |
| tgt_data | output | DATA_W (16) | Latched data of the completing write |
| mode | output | 2 | 00 array read, 01 identification, 10 query |
| id_data | output | DATA_W (16) | Identification code for rd_addr |
| id_valid | output | 1 | High while identification mode is active |

## Verification
Two things can fall in the same clock: the `busy` lock-out and the write that would complete a chain. The bench raises `busy` in exactly the clock where the final program write strobes, after a valid three-write unlock. It expects no start pulse and an unchanged mode. It then drops `busy`, repeats only the final write, and expects the program to start with that write's address and data, which shows the lock-out neither completed nor discarded the chain. The same collision is provoked for the single-write F0h exit in identification mode, where `mode` must stay 01.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

    localparam int CMD_AW = 15;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] ADDR_KEY_A = 15'h5555;
    localparam logic [CMD_AW-1:0] ADDR_KEY_B = 15'h2AAA;

    localparam logic [CMD_DW-1:0] KEY_AA   = 8'hAA;
    localparam logic [CMD_DW-1:0] KEY_55   = 8'h55;
    localparam logic [CMD_DW-1:0] CMD_PROG = 8'hA0;
    localparam logic [CMD_DW-1:0] CMD_ERAS = 8'h80;
    localparam logic [CMD_DW-1:0] CMD_IDEN = 8'h90;
    localparam logic [CMD_DW-1:0] CMD_QURY = 8'h98;
    localparam logic [CMD_DW-1:0] CMD_EXIT = 8'hF0;
    localparam logic [CMD_DW-1:0] CMD_SECT = 8'h30;
    localparam logic [CMD_DW-1:0] CMD_BLK  = 8'h50;
    localparam logic [CMD_DW-1:0] CMD_CHIP = 8'h10;

    typedef enum logic [1:0] {
        MODE_READ  = 2'b00,
        MODE_IDENT = 2'b01,
        MODE_QUERY = 2'b10
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_ERA3,
        SQ_ERA4,
        SQ_ERA5
    } seq_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_BLK,
        OP_CHIP
    } op_e;

    typedef struct packed {
        logic at_a;
        logic at_b;
        logic d_aa;
        logic d_55;
        logic d_prog;
        logic d_eras;
        logic d_iden;
        logic d_qury;
        logic d_exit;
        logic d_sect;
        logic d_blk;
        logic d_chip;
    } cyc_t;

    function automatic logic key_a_hit(cyc_t c);
        return c.at_a && c.d_aa;
    endfunction

    function automatic logic key_b_hit(cyc_t c);
        return c.at_b && c.d_55;
    endfunction

endpackage

// File: rtl/ucd_cycle_match.sv
module ucd_cycle_match
    import ucd_pkg::*;
(
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [CMD_DW-1:0] data_lo,
    output cyc_t              cyc
);

    always_comb begin
        cyc.at_a   = (addr_lo == ADDR_KEY_A);
        cyc.at_b   = (addr_lo == ADDR_KEY_B);
        cyc.d_aa   = (data_lo == KEY_AA);
        cyc.d_55   = (data_lo == KEY_55);
        cyc.d_prog = (data_lo == CMD_PROG);
        cyc.d_eras = (data_lo == CMD_ERAS);
        cyc.d_iden = (data_lo == CMD_IDEN);
        cyc.d_qury = (data_lo == CMD_QURY);
        cyc.d_exit = (data_lo == CMD_EXIT);
        cyc.d_sect = (data_lo == CMD_SECT);
        cyc.d_blk  = (data_lo == CMD_BLK);
        cyc.d_chip = (data_lo == CMD_CHIP);
    end

endmodule

// File: rtl/ucd_seq_fsm.sv
module ucd_seq_fsm
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              busy,
    input  cyc_t              cyc,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output op_e               op_pulse,
    output op_e               op_kind,
    output mode_e             mode_q,
    output logic [ADDR_W-1:0] raw_addr,
    output logic [DATA_W-1:0] raw_data
);

    seq_e  seq_q, seq_n;
    mode_e mode_n;
    op_e   op_n;
    logic  take;
    logic  abort;

    always_comb begin
        seq_n  = seq_q;
        mode_n = mode_q;
        op_n   = OP_NONE;
        abort  = 1'b0;
        take   = wr_stb && !busy;
        if (take) begin
            unique case (seq_q)
                SQ_IDLE: begin
                    if (key_a_hit(cyc)) seq_n = SQ_KEY1;
                    else                abort = 1'b1;
                end
                SQ_KEY1: begin
                    if (key_b_hit(cyc)) seq_n = SQ_KEY2;
                    else                abort = 1'b1;
                end
                SQ_KEY2: begin
                    if (!cyc.at_a)       abort = 1'b1;
                    else if (cyc.d_prog) seq_n = SQ_PROG;
                    else if (cyc.d_eras) seq_n = SQ_ERA3;
                    else if (cyc.d_iden) begin
                        seq_n  = SQ_IDLE;
                        mode_n = MODE_IDENT;
                    end else if (cyc.d_qury) begin
                        seq_n  = SQ_IDLE;
                        mode_n = MODE_QUERY;
                    end else if (cyc.d_exit) begin
                        seq_n  = SQ_IDLE;
                        mode_n = MODE_READ;
                    end else abort = 1'b1;
                end
                SQ_PROG: begin
                    seq_n  = SQ_IDLE;
                    mode_n = MODE_READ;
                    op_n   = OP_PROG;
                end
                SQ_ERA3: begin
                    if (key_a_hit(cyc)) seq_n = SQ_ERA4;
                    else                abort = 1'b1;
                end
                SQ_ERA4: begin
                    if (key_b_hit(cyc)) seq_n = SQ_ERA5;
                    else                abort = 1'b1;
                end
                SQ_ERA5: begin
                    seq_n  = SQ_IDLE;
                    mode_n = MODE_READ;
                    if (cyc.d_sect)                  op_n = OP_SECT;
                    else if (cyc.d_blk)              op_n = OP_BLK;
                    else if (cyc.d_chip && cyc.at_a) op_n = OP_CHIP;
                    else                             abort = 1'b1;
                end
                default: abort = 1'b1;
            endcase
            if (abort) begin
                seq_n  = SQ_IDLE;
                mode_n = MODE_READ;
                op_n   = OP_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q    <= SQ_IDLE;
            mode_q   <= MODE_READ;
            op_pulse <= OP_NONE;
            op_kind  <= OP_NONE;
            raw_addr <= '0;
            raw_data <= '0;
        end else begin
            seq_q    <= seq_n;
            mode_q   <= mode_n;
            op_pulse <= op_n;
            if (op_n != OP_NONE) begin
                op_kind  <= op_n;
                raw_addr <= wr_addr;
                raw_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/ucd_target_align.sv
module ucd_target_align
    import ucd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  op_e               kind,
    input  logic [ADDR_W-1:0] raw,
    output logic [ADDR_W-1:0] aligned
);

    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

    always_comb begin
        unique case (kind)
            OP_SECT: aligned = raw & SECT_MASK;
            OP_BLK:  aligned = raw & BLK_MASK;
            OP_CHIP: aligned = '0;
            default: aligned = raw;
        endcase
    end

endmodule

// File: rtl/ucd_id_rom.sv
module ucd_id_rom
    import ucd_pkg::*;
#(
    parameter int                ADDR_W   = 18,
    parameter int                DATA_W   = 16,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00C5,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h5A3C
) (
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_data,
    output logic              id_valid
);

    localparam logic [ADDR_W-1:0] LOC_MFR = '0;
    localparam logic [ADDR_W-1:0] LOC_DEV = ADDR_W'(1);

    always_comb begin
        id_valid = (mode == MODE_IDENT);
        id_data  = '0;
        if (id_valid) begin
            if (rd_addr == LOC_MFR)      id_data = MFR_CODE;
            else if (rd_addr == LOC_DEV) id_data = DEV_CODE;
        end
    end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import ucd_pkg::*;
#(
    parameter int                ADDR_W   = 18,
    parameter int                DATA_W   = 16,
    parameter int                SECT_LSB = 11,
    parameter int                BLK_LSB  = 15,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00C5,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              start_prog,
    output logic              start_sect,
    output logic              start_blk,
    output logic              start_chip,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic [1:0]        mode,
    output logic [DATA_W-1:0] id_data,
    output logic              id_valid
);

    cyc_t              cyc;
    op_e               op_pulse;
    op_e               op_kind;
    mode_e             mode_q;
    logic [ADDR_W-1:0] raw_addr;

    ucd_cycle_match u_match (
        .addr_lo (wr_addr[CMD_AW-1:0]),
        .data_lo (wr_data[CMD_DW-1:0]),
        .cyc     (cyc)
    );

    ucd_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .busy     (busy),
        .cyc      (cyc),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .op_pulse (op_pulse),
        .op_kind  (op_kind),
        .mode_q   (mode_q),
        .raw_addr (raw_addr),
        .raw_data (tgt_data)
    );

    ucd_target_align #(
        .ADDR_W   (ADDR_W),
        .SECT_LSB (SECT_LSB),
        .BLK_LSB  (BLK_LSB)
    ) u_align (
        .kind    (op_kind),
        .raw     (raw_addr),
        .aligned (tgt_addr)
    );

    ucd_id_rom #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_id (
        .mode     (mode_q),
        .rd_addr  (rd_addr),
        .id_data  (id_data),
        .id_valid (id_valid)
    );

    assign start_prog = (op_pulse == OP_PROG);
    assign start_sect = (op_pulse == OP_SECT);
    assign start_blk  = (op_pulse == OP_BLK);
    assign start_chip = (op_pulse == OP_CHIP);
    assign mode       = mode_q;

endmodule

// File: rtl/ucd_chk.sv
module ucd_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic              busy,
    input logic              start_prog,
    input logic              start_sect,
    input logic              start_blk,
    input logic              start_chip,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [1:0]        mode
);

    logic [3:0] starts;
    assign starts = {start_prog, start_sect, start_blk, start_chip};

    // R11
    start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(starts));

    // R11
    start_single_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (starts != 4'b0) |=> (starts == 4'b0));

    // R11
    start_read_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (starts != 4'b0) |-> (mode == 2'b00));

    // R9
    busy_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> ((starts == 4'b0) && $stable(mode)));

    // R8
    quiet_without_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_stb) |-> ((starts == 4'b0) && $stable(mode) && $stable(tgt_addr)));

endmodule

bind unlock_cmd_decoder ucd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .busy       (busy),
    .start_prog (start_prog),
    .start_sect (start_sect),
    .start_blk  (start_blk),
    .start_chip (start_chip),
    .tgt_addr   (tgt_addr),
    .mode       (mode)
);

// File: tb/unlock_cmd_decoder_tb.sv
module unlock_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam logic [DW-1:0] MFR = 16'h00C5;
    localparam logic [DW-1:0] DEV = 16'h5A3C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          start_prog, start_sect, start_blk, start_chip;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic [1:0]    mode;
    logic [DW-1:0] id_data;
    logic          id_valid;

    int   checks = 0;
    int   errors = 0;
    logic [2:0] hb3 = 3'd0;
    logic [7:0] hb8 = 8'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unlock_cmd_decoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .rd_addr    (rd_addr),
        .start_prog (start_prog),
        .start_sect (start_sect),
        .start_blk  (start_blk),
        .start_chip (start_chip),
        .tgt_addr   (tgt_addr),
        .tgt_data   (tgt_data),
        .mode       (mode),
        .id_data    (id_data),
        .id_valid   (id_valid)
    );

    function automatic logic [AW-1:0] ka(input logic [14:0] lo);
        return {hb3, lo};
    endfunction

    function automatic logic [DW-1:0] kd(input logic [7:0] lo);
        return {hb8, lo};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one write cycle; outputs of its clock edge are visible on return
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_addr = a;
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic pre3(input logic [7:0] cmd);
        wr(ka(15'h5555), kd(8'hAA));
        wr(ka(15'h2AAA), kd(8'h55));
        wr(ka(15'h5555), kd(cmd));
    endtask

    task automatic erase_prefix(input int n);
        if (n > 0) wr(ka(15'h5555), kd(8'hAA));
        if (n > 1) wr(ka(15'h2AAA), kd(8'h55));
        if (n > 2) wr(ka(15'h5555), kd(8'h80));
        if (n > 3) wr(ka(15'h5555), kd(8'hAA));
        if (n > 4) wr(ka(15'h2AAA), kd(8'h55));
    endtask

    function automatic logic [3:0] sv4();
        return {start_prog, start_sect, start_blk, start_chip};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 mode", 32'(mode), 32'h0);
        chk("R12 starts", 32'(sv4()), 32'h0);
        chk("R12 tgt_addr", 32'(tgt_addr), 32'h0);
        chk("R12 tgt_data", 32'(tgt_data), 32'h0);

        // R1 and R10: program with varied high address and data bits
        for (int i = 0; i < 8; i++) begin
            hb3 = 3'(i);
            hb8 = 8'(i * 37 + 1);
            pre3(8'hA0);
            chk("R1 no early start", 32'(sv4()), 32'h0);
            a = AW'(i * 32771 + 5);
            d = DW'(i * 4099 + 3);
            wr(a, d);
            chk("R1 start_prog", 32'(sv4()), 32'h8);
            chk("R1 tgt_addr", 32'(tgt_addr), 32'(a));
            chk("R1 tgt_data", 32'(tgt_data), 32'(d));
            chk("R11 mode at start", 32'(mode), 32'h0);
            @(negedge clk);
            chk("R11 one clock", 32'(sv4()), 32'h0);
            chk("R10 held target", 32'(tgt_addr), 32'(a));
        end

        // R2 sector sweep over all indices
        for (int i = 0; i < 128; i++) begin
            hb3 = 3'(i * 5);
            hb8 = 8'(i * 11);
            erase_prefix(5);
            a = {7'(i), 11'(i * 13 + 1)};
            wr(a, kd(8'h30));
            chk("R2 start_sect", 32'(sv4()), 32'h4);
            chk("R2 sector base", 32'(tgt_addr), 32'({7'(i), 11'd0}));
        end

        // R3 block sweep
        for (int i = 0; i < 8; i++) begin
            hb3 = 3'(7 - i);
            hb8 = 8'(i * 29);
            erase_prefix(5);
            a = {3'(i), 15'(i * 999 + 7)};
            wr(a, kd(8'h50));
            chk("R3 start_blk", 32'(sv4()), 32'h2);
            chk("R3 block base", 32'(tgt_addr), 32'({3'(i), 15'd0}));
        end

        // R4 chip erase and misplaced chip command
        hb3 = 3'd6; hb8 = 8'h3C;
        erase_prefix(5);
        wr(ka(15'h5555), kd(8'h10));
        chk("R4 start_chip", 32'(sv4()), 32'h1);
        chk("R4 tgt zero", 32'(tgt_addr), 32'h0);
        erase_prefix(5);
        wr(ka(15'h1234), kd(8'h10));
        chk("R4 bad address no start", 32'(sv4()), 32'h0);
        chk("R4 bad address mode", 32'(mode), 32'h0);

        // R5 and R6 identification
        hb3 = 3'd2; hb8 = 8'hE1;
        pre3(8'h90);
        chk("R5 ident mode", 32'(mode), 32'h1);
        for (int r = 0; r < 4; r++) begin
            rd_addr = AW'(r);
            #1;
            chk("R6 id_valid", 32'(id_valid), 32'h1);
            chk("R6 id_data", 32'(id_data), (r == 0) ? 32'(MFR) : (r == 1) ? 32'(DEV) : 32'h0);
        end
        rd_addr = '0;

        // R7 single-write exit at arbitrary address
        wr(18'h2F0F0 ^ 18'h01234, 16'h77F0);
        chk("R7 single exit mode", 32'(mode), 32'h0);
        #1;
        chk("R6 id off", 32'(id_valid), 32'h0);
        chk("R6 id data off", 32'(id_data), 32'h0);

        // R5 query, R7 three-write exit
        pre3(8'h98);
        chk("R5 query mode", 32'(mode), 32'h2);
        #1;
        chk("R6 no id in query", 32'(id_valid), 32'h0);
        pre3(8'hF0);
        chk("R7 chain exit mode", 32'(mode), 32'h0);

        // R8 abort at every position of the erase chain, from identification mode
        for (int p = 0; p < 6; p++) begin
            pre3(8'h90);
            erase_prefix(p);
            wr(ka(15'h5555), kd(8'h77));
            chk("R8 abort mode", 32'(mode), 32'h0);
            chk("R8 abort no start", 32'(sv4()), 32'h0);
            pre3(8'hA0);
            wr(18'h0ABCD, 16'h1357);
            chk("R8 clean restart", 32'(sv4()), 32'h8);
        end

        // R9 busy: exit ignored, whole program ignored, chain preserved
        pre3(8'h90);
        busy = 1'b1;
        wr(18'h00000, 16'h00F0);
        chk("R9 exit ignored", 32'(mode), 32'h1);
        pre3(8'hA0);
        wr(18'h01111, 16'h2222);
        chk("R9 program ignored", 32'(sv4()), 32'h0);
        chk("R9 mode kept", 32'(mode), 32'h1);
        busy = 1'b0;
        wr(ka(15'h5555), kd(8'hAA));
        wr(ka(15'h2AAA), kd(8'h55));
        busy = 1'b1;
        wr(18'h00100, 16'h0012);
        busy = 1'b0;
        wr(ka(15'h5555), kd(8'hA0));
        busy = 1'b1;
        wr(18'h3C0DE, 16'hBEEF);
        chk("R9 final write under busy", 32'(sv4()), 32'h0);
        busy = 1'b0;
        wr(18'h3C0DE, 16'hBEEF);
        chk("R9 chain resumed", 32'(sv4()), 32'h8);
        chk("R9 tgt_addr", 32'(tgt_addr), 32'h3C0DE);
        chk("R9 tgt_data", 32'(tgt_data), 32'hBEEF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule